// File: doc/BRIEF.md
# Teletext Bit Fetcher

This block pulls a serial teletext bitstream from an external source, one bit per request. A phase accumulator on the 27 MHz system clock sets the bit period for either of the two broadcast teletext rates. Each time the accumulator wraps, the block raises a one-cycle request pulse. After a programmable number of system clocks it samples the serial input. The sampled bits come out one at a time with a valid strobe. They are also packed into bytes for the inserter that places them on the active teletext lines.

Requests are issued only while the line window is open. A per-line limit caps how many bits are fetched. The serial pin is shared with a real-time control function. While that function owns the pin, the block issues no requests, drops every sample still pending and discards any partly filled byte.

Top module: `ttx_bit_fetch`

## Requirements
- R1: After reset, `req_o`, `bit_valid_o`, `bit_o` and `word_valid_o` are low and `word_o` is zero.
- R2: `req_o` is a pulse exactly one clock wide, and every pulse is followed by at least one low cycle, so each rising edge asks for exactly one bit.
- R3: The bit period comes from an ACC_W-bit phase accumulator. It is cleared whenever the block is inactive and advanced by a fixed step on every active clock. `req_o` rises in the cycle after each carry out. The step is floor(rate * 2^ACC_W / 27 000 000), with rate 6 937 500 bit/s when `rate_sel`=0 and 5 727 272 bit/s when `rate_sel`=1. A window of N active clocks therefore yields floor(N * step / 2^ACC_W) requests.
- R4: When `req_o` is high in cycle T, `ser_in` is sampled at the clock edge that ends cycle T+`dly`, where `dly` is 0 to 15. In the next cycle `bit_valid_o` is high for one clock and `bit_o` carries the sample. `bit_o` holds its value until the next sample.
- R5: Within one high period of `line_en`, at most `bits_per_line` requests are issued. The count restarts whenever `line_en` is low.
- R6: Sampled bits are packed so that the earliest bit lands in bit 0 of `word_o`. One clock after the BUF_W-th sample is presented, `word_valid_o` pulses for one cycle and `word_o` holds the completed byte until the next one is complete.
- R7: `req_o` is high only in a cycle that follows a clock edge at which `line_en` was high.
- R8: While `rtc_mode`=1, `req_o` stays low and no sample is taken. Samples still pending are discarded, and the partly packed byte is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Teletext line window; requests only while high |
| rate_sel | input | 1 | Bit-rate select: 0 = 6.9375 Mbit/s, 1 = 5.727 Mbit/s |
| rtc_mode | input | 1 | 1 = pin given to real-time control, fetching halted |
| dly | input | DLY_W (4) | Sample delay in clocks after the request cycle |
| bits_per_line | input | CNT_W (10) | Maximum requests per line window |
| ser_in | input | 1 | Serial teletext data from the source |
| req_o | output | 1 | One-cycle bit request pulse |
| bit_valid_o | output | 1 | Sample strobe, one cycle |
| bit_o | output | 1 | Last sampled bit |
| word_valid_o | output | 1 | Packed byte strobe, one cycle |
| word_o | output | BUF_W (8) | Last packed byte, earliest bit in bit 0 |

## Verification
The bench runs windows with the delay at 0, 3 and 15. A design with an off-by-one delay tap would return the neighbouring bit of a random stream, and its bit and byte streams would diverge from the model at once. One window is long enough that the per-line limit cuts it short. A counter that does not stop, or does not restart when the window closes, would show up as a wrong request total. The low rate is counted over a long window without a limit, so a wrong phase step or a lost carry would miscount. Real-time control is switched on in the middle of a window while samples are still pending. A design that still samples, keeps its pending samples or keeps a half byte would deliver bits or a byte that the model does not expect.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int unsigned SYS_HZ   = 27_000_000;
  localparam int unsigned FAST_HZ  = 6_937_500;
  localparam int unsigned SLOW_HZ  = 5_727_272;

  // Phase step for a given bit rate on the system clock
  function automatic int unsigned phase_step(input int unsigned rate_hz,
                                             input int unsigned acc_w);
    longint unsigned num;
    num = longint'(rate_hz) << acc_w;
    return int'(num / longint'(SYS_HZ));
  endfunction
endpackage

// File: rtl/ttx_rate_gen.sv
module ttx_rate_gen #(
  parameter int ACC_W = 24,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             rtc_mode,
  input  logic             rate_sel,
  input  logic [CNT_W-1:0] bits_per_line,
  output logic             tick
);
  import ttx_pkg::*;
  localparam logic [ACC_W-1:0] STEP_FAST = ACC_W'(phase_step(FAST_HZ, ACC_W));
  localparam logic [ACC_W-1:0] STEP_SLOW = ACC_W'(phase_step(SLOW_HZ, ACC_W));

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic [CNT_W-1:0] cnt;
  logic             active;

  assign active = line_en && !rtc_mode && (cnt < bits_per_line);
  assign sum    = {1'b0, acc} + {1'b0, (rate_sel ? STEP_SLOW : STEP_FAST)};
  assign tick   = active && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (active)  acc <= sum[ACC_W-1:0];
    else              acc <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !line_en) cnt <= '0;
    else if (tick)          cnt <= cnt + 1'b1;
  end

  // R5: the line count never passes the limit while the limit is held
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_en) && line_en && $stable(bits_per_line) && $past(cnt) <= bits_per_line)
      |-> (cnt <= bits_per_line));
endmodule

// File: rtl/ttx_sample_delay.sv
module ttx_sample_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rtc_mode,
  input  logic [DLY_W-1:0] dly,
  input  logic             ser_in,
  output logic             req_o,
  output logic             bit_valid_o,
  output logic             bit_o
);
  localparam int TAPS = 1 << DLY_W;

  // hist[k] is high when the request was high k cycles ago
  logic [TAPS-1:0] hist;
  logic            take_now;

  assign req_o    = hist[0];
  assign take_now = hist[dly] && !rtc_mode;

  always_ff @(posedge clk) begin
    if (!rst_n || rtc_mode) hist <= '0;
    else                    hist <= {hist[TAPS-2:0], tick};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
    end else begin
      bit_valid_o <= take_now;
      if (take_now) bit_o <= ser_in;
    end
  end

  // R2: request is a single-cycle pulse
  a_r2_single_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
  // R8: no sample follows an edge where real-time control held the pin
  a_r8_no_capture_in_rtc: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> !$past(rtc_mode));
endmodule

// File: rtl/ttx_shift_buf.sv
module ttx_shift_buf #(
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_mode,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             word_valid_o,
  output logic [BUF_W-1:0] word_o
);
  localparam int N_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] shreg;
  logic [BUF_W-1:0] shifted;
  logic [N_W-1:0]   fill;
  logic             full_now;

  assign shifted  = {bit_in, shreg[BUF_W-1:1]};
  assign full_now = bit_valid && (fill == N_W'(BUF_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg        <= '0;
      fill         <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (rtc_mode) begin
        fill <= '0;
      end else if (bit_valid) begin
        shreg <= shifted;
        if (full_now) begin
          word_o       <= shifted;
          word_valid_o <= 1'b1;
          fill         <= '0;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  // R6: a byte completes only on the cycle after a presented bit
  a_r6_word_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(bit_valid));
endmodule

// File: rtl/ttx_bit_fetch.sv
module ttx_bit_fetch #(
  parameter int ACC_W = 24,
  parameter int DLY_W = 4,
  parameter int CNT_W = 10,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             rate_sel,
  input  logic             rtc_mode,
  input  logic [DLY_W-1:0] dly,
  input  logic [CNT_W-1:0] bits_per_line,
  input  logic             ser_in,
  output logic             req_o,
  output logic             bit_valid_o,
  output logic             bit_o,
  output logic             word_valid_o,
  output logic [BUF_W-1:0] word_o
);
  logic bit_tick;

  ttx_rate_gen #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .rtc_mode(rtc_mode),
    .rate_sel(rate_sel), .bits_per_line(bits_per_line), .tick(bit_tick));

  ttx_sample_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rtc_mode(rtc_mode),
    .dly(dly), .ser_in(ser_in), .req_o(req_o),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o));

  ttx_shift_buf #(.BUF_W(BUF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .rtc_mode(rtc_mode), .bit_valid(bit_valid_o),
    .bit_in(bit_o), .word_valid_o(word_valid_o), .word_o(word_o));

  // R7: requests only follow an edge inside the line window
  a_r7_req_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(line_en));
  // R8: no request follows an edge where real-time control held the pin
  a_r8_no_req_in_rtc: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !$past(rtc_mode));
endmodule

// File: tb/ttx_bit_fetch_tb.sv
module ttx_bit_fetch_tb;
  localparam int ACC_W = 24, DLY_W = 4, CNT_W = 10, BUF_W = 8;

  logic clk = 0, rst_n = 0, line_en = 0, rate_sel = 0, rtc_mode = 0, ser_in = 0;
  logic [DLY_W-1:0] dly = '0;
  logic [CNT_W-1:0] bits_per_line = '0;
  logic req_o, bit_valid_o, bit_o, word_valid_o;
  logic [BUF_W-1:0] word_o;

  int n_chk = 0, n_fail = 0;
  int unsigned rng = 32'h1234_5678;

  always #2 clk = ~clk;

  ttx_bit_fetch #(.ACC_W(ACC_W), .DLY_W(DLY_W), .CNT_W(CNT_W), .BUF_W(BUF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .rate_sel(rate_sel),
    .rtc_mode(rtc_mode), .dly(dly), .bits_per_line(bits_per_line), .ser_in(ser_in),
    .req_o(req_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o),
    .word_valid_o(word_valid_o), .word_o(word_o));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  longint unsigned m_acc;
  int  m_cnt, m_fill, edge_no;
  bit  m_req, m_cap, m_bit, m_pcap, m_pbit, m_wv;
  int  m_word, m_shreg;
  int  due[$];

  function automatic longint unsigned step_of(input bit slow);
    return ((slow ? 64'd5727272 : 64'd6937500) << ACC_W) / 64'd27000000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_fill = 0; edge_no = 0;
      m_req = 0; m_cap = 0; m_bit = 0; m_pcap = 0; m_pbit = 0; m_wv = 0;
      m_word = 0; m_shreg = 0; due.delete();
    end else begin
      bit act, tk;
      longint unsigned s;
      // byte packing of the sample presented last cycle
      m_wv = 0;
      if (rtc_mode) m_fill = 0;
      else if (m_pcap) begin
        m_shreg = (m_shreg >> 1) | (int'(m_pbit) << (BUF_W - 1));
        if (m_fill == BUF_W - 1) begin m_word = m_shreg; m_wv = 1; m_fill = 0; end
        else m_fill++;
      end
      // delayed sampling
      m_cap = 0;
      if (due.size() > 0 && due[0] == edge_no) begin
        void'(due.pop_front());
        if (!rtc_mode) begin m_cap = 1; m_bit = ser_in; end
      end
      if (rtc_mode) due.delete();
      // bit-rate accumulator
      act = line_en && !rtc_mode && (m_cnt < int'(bits_per_line));
      tk = 0;
      if (act) begin
        s = m_acc + step_of(rate_sel);
        tk = s[ACC_W];
        m_acc = s & ((64'd1 << ACC_W) - 1);
      end else m_acc = 0;
      if (tk) due.push_back(edge_no + 1 + int'(dly));
      m_req = tk;
      if (!line_en) m_cnt = 0; else if (tk) m_cnt++;
      m_pcap = m_cap; m_pbit = m_bit;
      edge_no++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_o == m_req, "R2 req_o", req_o, m_req);
      chk(bit_valid_o == m_cap, "R4 bit_valid_o", bit_valid_o, m_cap);
      if (m_cap) chk(bit_o == m_bit, "R4 bit_o", bit_o, m_bit);
      chk(word_valid_o == m_wv, "R6 word_valid_o", word_valid_o, m_wv);
      if (m_wv) chk(int'(word_o) == m_word, "R6 word_o", word_o, m_word);
    end
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    ser_in <= rng[7];
  end

  // ---------------- stimulus ----------------
  int win_reqs, idle_reqs;

  task automatic run_win(input bit slow, input int d, input int lim, input int n);
    @(negedge clk);
    rate_sel = slow; dly = DLY_W'(d); bits_per_line = CNT_W'(lim); line_en = 1;
    win_reqs = 0; idle_reqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_o) win_reqs++;
    end
    line_en = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (req_o) idle_reqs++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!req_o && !bit_valid_o && !bit_o && !word_valid_o, "R1 reset outputs", req_o, 0);
    chk(word_o == 0, "R1 reset word_o", word_o, 0);
    rst_n = 1;

    // fast rate, delay 3, limit hits inside the window
    run_win(0, 3, 40, 200);
    chk(win_reqs == 40, "R5 per-line limit", win_reqs, 40);
    chk(idle_reqs == 0, "R7 no request outside window", idle_reqs, 0);

    // slow rate, delay 0, long unlimited window
    run_win(1, 0, 1000, 300);
    chk(win_reqs == int'((64'd300 * step_of(1)) >> ACC_W), "R3 slow rate count",
        win_reqs, (64'd300 * step_of(1)) >> ACC_W);
    chk(idle_reqs == 0, "R7 no request outside window", idle_reqs, 0);

    // fast rate, maximum delay
    run_win(0, 15, 1000, 250);
    chk(win_reqs == int'((64'd250 * step_of(0)) >> ACC_W), "R3 fast rate count",
        win_reqs, (64'd250 * step_of(0)) >> ACC_W);

    // limit restarts on a new window
    run_win(0, 5, 12, 100);
    chk(win_reqs == 12, "R5 count restarts per line", win_reqs, 12);

    // real-time control takes the pin mid-window
    @(negedge clk);
    rate_sel = 0; dly = 4'd9; bits_per_line = 10'd1000; line_en = 1;
    repeat (61) @(negedge clk);
    rtc_mode = 1;
    begin
      int rq = 0, bv = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (req_o) rq++;
        if (bit_valid_o) bv++;
      end
      chk(rq == 0, "R8 no request in rtc mode", rq, 0);
      chk(bv == 0, "R8 no sample in rtc mode", bv, 0);
    end
    rtc_mode = 0;
    repeat (80) @(negedge clk);
    line_en = 0;
    repeat (30) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule